// File: doc/BRIEF.md
# Batched Lane Pixel Streamer

This block sits between a one-pixel-per-cycle stream and a row of identical per-pixel processing lanes. It gathers consecutive pixels of a frame into fixed-size batches, one pixel per lane. It hands a whole batch to the lanes at once and takes all lane results back in one cycle. It then serialises those results onto a one-result-per-cycle output stream, in the same order the pixels arrived.

Three buffer sets are used in rotation. One set is being filled from the input, one is held by the lanes, and one is being emptied to the output. Every lane owns its own bank in each set, so the parallel read for the lanes and the parallel result write never compete for a port. When all three stages are finished, the roles move on by one set. Filling, computing and emptying therefore overlap, and with a free output and quick lanes the input never waits.

A frame whose length is not a multiple of the batch size ends in a short batch. The unused lanes are flagged as padding, and their results never appear at the output. An output stall backs up through the rotation to the input without dropping or repeating anything.

Top module: `pix_batch_stream`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `lane_go` is 0. Any partly loaded data from before the reset never reaches the output.
- R2: Every accepted pixel produces exactly one output result, and results leave in the order their pixels were accepted.
- R3: The pixel at position p of a frame (counting from 0) is presented to lane p mod LANES, in bits [k*PIX_W +: PIX_W] of `lane_pix` for lane k. The output result for it is the one that lane returned in `lane_res` bits [k*RES_W +: RES_W].
- R4: `lane_go` is high for exactly one cycle for each non-empty batch. The lanes answer with a one-cycle `lane_ack` in some later cycle, and the block captures `lane_res` in that cycle.
- R5: A frame ends at the pixel carrying `in_last`, and that pixel closes the current batch even when the batch is short. At `lane_go`, bit k of `lane_mask` is 1 exactly for the lanes holding a real pixel, so the mask is always a nonzero run of ones from bit 0. Results from lanes with a 0 mask bit are never output.
- R6: `out_last` is high together with the result of the last pixel of each frame and at no other time. It is only high while `out_valid` is high.
- R7: When `out_ready` stays 1 and the lanes acknowledge within a few cycles, `in_ready` stays 1 across full batches, so one pixel is accepted every clock.
- R8: While `out_valid` is 1 and `out_ready` is 0, the next cycle still shows `out_valid` high with `out_res` and `out_last` unchanged.
- R9: `in_ready` drops only when the loading set is closed and the pipeline cannot yet rotate. No pixel offered with `in_ready` high is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take the input pixel |
| in_pix | input | PIX_W | Input pixel value |
| in_last | input | 1 | Input pixel is the last of its frame |
| lane_go | output | 1 | One-cycle start pulse for the lanes |
| lane_mask | output | LANES | Lanes holding a real pixel |
| lane_pix | output | LANES*PIX_W | Pixel for each lane, lane 0 in the low bits |
| lane_ack | input | 1 | Lane results are present on lane_res |
| lane_res | input | LANES*RES_W | Result of each lane, lane 0 in the low bits |
| out_valid | output | 1 | Output result present |
| out_ready | input | 1 | Consumer takes the output result |
| out_res | output | RES_W | Output result value |
| out_last | output | 1 | Output result is the last of its frame |

## Verification
A rotation pointer that gets out of step with the set counts shows up at the ports within one batch. It appears as a lane result on the wrong output position, a batch emitted twice, or a frame's results arriving in the wrong order. All three are caught on the first result compared against the bench's own position-based expectation. A lost closing condition or padding count shows as a wrong `lane_mask` at the very next `lane_go`, or as an `out_last` on the wrong result or a missing one. A stage that is slow to report it has finished shows up as extra input stall cycles in the first full frame after reset.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

   // Index of one of the three rotating buffer sets.
   typedef logic [1:0] set_t;

   localparam int unsigned NUM_SETS = 3;

   // Successor of a set index, wrapping after the third set.
   function automatic set_t set_next(input set_t s);
      return (s == set_t'(NUM_SETS - 1)) ? set_t'(0) : s + set_t'(1);
   endfunction

endpackage

// File: rtl/pbs_lane_bank.sv
module pbs_lane_bank
   import pbs_pkg::*;
#(
   parameter int unsigned PIX_W = 8,
   parameter int unsigned RES_W = 9
) (
   input  logic             clk,
   input  logic             pix_we,
   input  set_t             pix_set,
   input  logic [PIX_W-1:0] pix_d,
   input  logic             res_we,
   input  set_t             res_set,
   input  logic [RES_W-1:0] res_d,
   input  set_t             cp_set,
   output logic [PIX_W-1:0] pix_q,
   input  set_t             dr_set,
   output logic [RES_W-1:0] res_q
);

   // One bank per set: this lane's pixel and result slot.
   logic [PIX_W-1:0] pix_mem [NUM_SETS];
   logic [RES_W-1:0] res_mem [NUM_SETS];

   always_ff @(posedge clk) begin
      if (pix_we) pix_mem[pix_set] <= pix_d;
      if (res_we) res_mem[res_set] <= res_d;
   end

   assign pix_q = pix_mem[cp_set];
   assign res_q = res_mem[dr_set];

endmodule

// File: rtl/pbs_drain.sv
module pbs_drain #(
   parameter int unsigned LANES = 4,
   parameter int unsigned RES_W = 9,
   localparam int unsigned IDX_W = $clog2(LANES),
   localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rotate,
   input  logic [CNT_W-1:0]       dr_cnt,
   input  logic                   dr_eof,
   input  logic [LANES*RES_W-1:0] res_flat,
   input  logic                   out_ready,
   output logic                   out_valid,
   output logic [RES_W-1:0]       out_res,
   output logic                   out_last,
   output logic                   dr_fin
);

   logic [CNT_W-1:0] idx_q;
   logic [IDX_W-1:0] sel;
   logic             final_item;
   logic             fire;

   assign sel        = idx_q[IDX_W-1:0];
   assign out_valid  = idx_q < dr_cnt;
   assign final_item = (CNT_W'(idx_q + 1'b1) == dr_cnt);
   assign out_res    = res_flat[sel*RES_W +: RES_W];
   assign out_last   = out_valid & dr_eof & final_item;
   assign fire       = out_valid & out_ready;
   assign dr_fin     = ~out_valid | (fire & final_item);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= '0;
      else if (rotate) idx_q <= '0;
      else if (fire)   idx_q <= idx_q + 1'b1;
   end

endmodule

// File: rtl/pix_batch_stream.sv
module pix_batch_stream
   import pbs_pkg::*;
#(
   parameter int unsigned LANES = 4,
   parameter int unsigned PIX_W = 8,
   parameter int unsigned RES_W = 9
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [PIX_W-1:0]       in_pix,
   input  logic                   in_last,
   output logic                   lane_go,
   output logic [LANES-1:0]       lane_mask,
   output logic [LANES*PIX_W-1:0] lane_pix,
   input  logic                   lane_ack,
   input  logic [LANES*RES_W-1:0] lane_res,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [RES_W-1:0]       out_res,
   output logic                   out_last
);

   localparam int unsigned IDX_W = $clog2(LANES);
   localparam int unsigned CNT_W = $clog2(LANES + 1);

   generate
      if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("LANES must be a power of two of at least 2");
      end
      if (PIX_W < 1 || RES_W < 1) begin : g_bad_width
         $error("PIX_W and RES_W must be positive");
      end
   endgenerate

   // Role pointers: load set is rot_q, then drain, then compute.
   set_t rot_q, ld_set, dr_set, cp_set;
   assign ld_set = rot_q;
   assign dr_set = set_next(rot_q);
   assign cp_set = set_next(dr_set);

   logic [CNT_W-1:0] cnt_q [NUM_SETS];
   logic             eof_q [NUM_SETS];
   logic             ld_closed_q, cp_started_q, cp_done_q;

   logic [CNT_W-1:0] ld_cnt, cp_cnt, dr_cnt;
   logic             in_fire, ld_close_now, ld_fin, cp_fin, dr_fin;
   logic             res_take, rotate;
   logic [LANES*RES_W-1:0] res_flat;

   assign ld_cnt = cnt_q[ld_set];
   assign cp_cnt = cnt_q[cp_set];
   assign dr_cnt = cnt_q[dr_set];

   // Load stage.
   assign in_ready     = ~ld_closed_q;
   assign in_fire      = in_valid & in_ready;
   assign ld_close_now = in_fire & (in_last | (ld_cnt == CNT_W'(LANES - 1)));
   assign ld_fin       = ld_closed_q | ld_close_now | ((ld_cnt == '0) & ~in_valid);

   // Compute stage.
   assign lane_go  = (cp_cnt != '0) & ~cp_started_q;
   assign res_take = lane_ack & cp_started_q & ~cp_done_q;
   assign cp_fin   = (cp_cnt == '0) | cp_done_q | res_take;

   // Roles move on only when every stage is finished.
   assign rotate = ld_fin & cp_fin & dr_fin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rot_q        <= set_t'(0);
         ld_closed_q  <= 1'b0;
         cp_started_q <= 1'b0;
         cp_done_q    <= 1'b0;
         for (int s = 0; s < NUM_SETS; s++) begin
            cnt_q[s] <= '0;
            eof_q[s] <= 1'b0;
         end
      end else begin
         if (in_fire) begin
            cnt_q[ld_set] <= ld_cnt + 1'b1;
            if (in_last) eof_q[ld_set] <= 1'b1;
         end
         if (rotate) begin
            rot_q         <= dr_set;
            cnt_q[dr_set] <= '0;
            eof_q[dr_set] <= 1'b0;
            ld_closed_q   <= 1'b0;
            cp_started_q  <= 1'b0;
            cp_done_q     <= 1'b0;
         end else begin
            if (ld_close_now) ld_closed_q  <= 1'b1;
            if (lane_go)      cp_started_q <= 1'b1;
            if (res_take)     cp_done_q    <= 1'b1;
         end
      end
   end

   // Per-lane banks: distribute on write, parallel read/write for the lanes.
   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         logic lane_we;
         assign lane_we      = in_fire & (ld_cnt[IDX_W-1:0] == IDX_W'(k));
         assign lane_mask[k] = (CNT_W'(k) < cp_cnt);

         pbs_lane_bank #(
            .PIX_W(PIX_W),
            .RES_W(RES_W)
         ) i_bank (
            .clk     (clk),
            .pix_we  (lane_we),
            .pix_set (ld_set),
            .pix_d   (in_pix),
            .res_we  (res_take),
            .res_set (cp_set),
            .res_d   (lane_res[k*RES_W +: RES_W]),
            .cp_set  (cp_set),
            .pix_q   (lane_pix[k*PIX_W +: PIX_W]),
            .dr_set  (dr_set),
            .res_q   (res_flat[k*RES_W +: RES_W])
         );
      end
   endgenerate

   // Collect stage.
   pbs_drain #(
      .LANES(LANES),
      .RES_W(RES_W)
   ) i_drain (
      .clk       (clk),
      .rst_n     (rst_n),
      .rotate    (rotate),
      .dr_cnt    (dr_cnt),
      .dr_eof    (eof_q[dr_set]),
      .res_flat  (res_flat),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .out_res   (out_res),
      .out_last  (out_last),
      .dr_fin    (dr_fin)
   );

endmodule

// File: rtl/pix_batch_stream_chk.sv
module pix_batch_stream_chk #(
   parameter int unsigned LANES = 4,
   parameter int unsigned RES_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lane_go,
   input logic [LANES-1:0] lane_mask,
   input logic             out_valid,
   input logic             out_ready,
   input logic [RES_W-1:0] out_res,
   input logic             out_last
);

   // R4: start pulse never lasts two cycles
   a_r4_go_single: assert property (@(posedge clk) disable iff (!rst_n)
      lane_go |=> !lane_go);

   // R5: mask is a nonzero run of ones from lane 0
   a_r5_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
      lane_go |-> (lane_mask != '0) && ((lane_mask & (lane_mask + 1'b1)) == '0));

   // R6: frame end marker only with a valid result
   a_r6_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   // R8: stalled output holds its value
   a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_last)));

endmodule

bind pix_batch_stream pix_batch_stream_chk #(
   .LANES(LANES),
   .RES_W(RES_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lane_go   (lane_go),
   .lane_mask (lane_mask),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_res   (out_res),
   .out_last  (out_last)
);

// File: tb/test_pix_batch_stream.sv
module test_pix_batch_stream;

   localparam int LANES = 4;
   localparam int PIX_W = 8;
   localparam int RES_W = 9;
   localparam int NVEC  = 22;

   // {last, pixel}: frames of 8, 6, 1 and 7 pixels
   localparam logic [PIX_W:0] VEC [NVEC] = '{
      9'h010, 9'h0FF, 9'h022, 9'h033, 9'h044, 9'h0FE, 9'h066, 9'h177,
      9'h081, 9'h092, 9'h0A3, 9'h0B4, 9'h0C5, 9'h1D6,
      9'h1FD,
      9'h001, 9'h002, 9'h003, 9'h0FC, 9'h005, 9'h006, 9'h107
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
   logic [PIX_W-1:0] in_pix = '0;
   logic in_ready, lane_go, out_valid, out_last;
   logic [LANES-1:0] lane_mask;
   logic [LANES*PIX_W-1:0] lane_pix;
   logic lane_ack;
   logic [LANES*RES_W-1:0] lane_res;
   logic [RES_W-1:0] out_res;

   always #5 clk = ~clk;

   pix_batch_stream #(.LANES(LANES), .PIX_W(PIX_W), .RES_W(RES_W)) i_pix_batch_stream (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_pix(in_pix), .in_last(in_last), .lane_go(lane_go), .lane_mask(lane_mask),
      .lane_pix(lane_pix), .lane_ack(lane_ack), .lane_res(lane_res),
      .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res), .out_last(out_last)
   );

   // Placeholder lanes: lane k returns its pixel plus k, one cycle after the start.
   logic ack_q;
   logic [LANES*RES_W-1:0] res_q;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_q <= 1'b0;
      else begin
         ack_q <= lane_go;
         if (lane_go)
            for (int k = 0; k < LANES; k++)
               res_q[k*RES_W +: RES_W] <= RES_W'(lane_pix[k*PIX_W +: PIX_W]) + RES_W'(k);
      end
   end
   assign lane_ack = ack_q;
   assign lane_res = res_q;

   int vectors = 0, fails = 0, cycles = 0;
   logic [RES_W-1:0] exp_res [256];
   logic             exp_last [256];
   int               exp_wr, exp_rd;
   logic [LANES-1:0] exp_mask [64];
   int               m_wr, m_rd;
   int               go_cnt, stalls8, frame_pos, sent;
   logic [15:0]      lfsr = 16'hACE1;

   task automatic chk(input logic ok, input string req, input int act, input int expv);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic clear_board();
      exp_wr = 0; exp_rd = 0; m_wr = 0; m_rd = 0;
      go_cnt = 0; stalls8 = 0; frame_pos = 0; sent = 0;
   endtask

   // One cycle: drive at the falling edge, then look at the settled outputs.
   task automatic step(input int first, input int count, input int rmode, input int gmode);
      logic [PIX_W:0] v;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk);
      v         = (sent < count) ? VEC[first + sent] : '0;
      in_valid  = (sent < count) && (gmode == 0 || lfsr[2]);
      in_pix    = v[PIX_W-1:0];
      in_last   = v[PIX_W];
      out_ready = (rmode == 0) || lfsr[5] || lfsr[9];
      #1;
      if (out_valid && out_ready) begin
         // R2 R3: order and lane routing; R6: frame end marker
         chk(exp_rd < exp_wr, "R2 extra result", exp_rd, exp_wr);
         chk(out_res == exp_res[exp_rd % 256], "R3 result value", int'(out_res), int'(exp_res[exp_rd % 256]));
         chk(out_last == exp_last[exp_rd % 256], "R6 out_last", int'(out_last), int'(exp_last[exp_rd % 256]));
         exp_rd++;
      end
      if (lane_go) begin
         go_cnt++;
         // R5: lanes holding real pixels
         chk(lane_mask == exp_mask[m_rd % 64], "R5 lane_mask", int'(lane_mask), int'(exp_mask[m_rd % 64]));
         m_rd++;
      end
      if (in_valid && !in_ready && sent < 8) stalls8++;
      if (in_valid && in_ready) begin
         exp_res[exp_wr % 256]  = RES_W'(in_pix) + RES_W'(frame_pos % LANES);
         exp_last[exp_wr % 256] = in_last;
         exp_wr++;
         if (in_last || (frame_pos % LANES) == LANES - 1) begin
            exp_mask[m_wr % 64] = LANES'((1 << ((frame_pos % LANES) + 1)) - 1);
            m_wr++;
         end
         frame_pos = in_last ? 0 : frame_pos + 1;
         sent++;
      end
   endtask

   task automatic run(input int first, input int count, input int rmode, input int gmode);
      int guard = 0;
      clear_board();
      while ((sent < count || exp_rd < exp_wr) && guard < 3000) begin
         step(first, count, rmode, gmode);
         guard++;
      end
      repeat (4) step(first, 0, rmode, gmode);
      // R2: every pixel came back exactly once
      chk(guard < 3000 && exp_rd == count, "R2 result count", exp_rd, count);
   endtask

   task automatic check_idle(input string tag);
      @(negedge clk); #1;
      chk(in_ready == 1'b1, tag, int'(in_ready), 1);
      chk(out_valid == 1'b0, tag, int'(out_valid), 0);
      chk(lane_go == 1'b0, tag, int'(lane_go), 0);
   endtask

   initial begin
      clear_board();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_idle("R1 reset state");

      // Table walk: all frames back to back, free output
      run(0, NVEC, 0, 0);
      chk(stalls8 == 0, "R7 full-rate input", stalls8, 0);
      chk(go_cnt == 7, "R4 start pulses", go_cnt, 7);

      // R8 R9: random output stalls and input gaps
      run(0, NVEC, 1, 1);
      chk(go_cnt == 7, "R4 start pulses under stalls", go_cnt, 7);
      run(8, 6, 1, 0);
      chk(go_cnt == 2, "R5 short batch pulses", go_cnt, 2);

      // R5 R6: single-pixel frame
      run(14, 1, 0, 0);
      chk(go_cnt == 1, "R5 single pixel pulse", go_cnt, 1);

      // R1: reset in the middle of a batch drops the partial load
      clear_board();
      for (int i = 0; i < 3; i++) step(0, 3, 0, 0);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check_idle("R1 reset mid-stream");
      for (int i = 0; i < 10; i++) begin
         @(negedge clk); #1;
         chk(out_valid == 1'b0, "R1 no stale output", int'(out_valid), 0);
      end
      run(15, 7, 1, 1);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule